// File: doc/BRIEF.md
# Signed Word-by-Halfword Divider

This execution unit divides a 32-bit two's-complement dividend by a signed 16-bit divisor. The divisor comes from the low half of a 32-bit operand, and the high half of that operand is ignored. A start strobe launches one division. The unit captures both operands and a mode bit. The mode bit selects whether the remainder is written back as well as the quotient. The unit then works on operand magnitudes with a radix-2 non-restoring recurrence, one quotient bit per cycle, and fixes the signs at the end.

When the result is ready, a single-cycle done pulse appears together with the quotient, the optional remainder and three flags: overflow, sign and zero. The result registers change only on that cycle. An abort input cancels a division in flight. An aborted division produces no pulse and changes no result, and the next start computes from scratch. Two cases have defined results: division by zero, and the most negative word divided by minus one. Both raise the overflow flag.

Top module: `wdiv_unit`

## Requirements
- R1: Only bits [15:0] of `divisor_op` take part in the division; bits [31:16] have no effect on any output.
- R2: The 16-bit divisor field is sign-extended before dividing, so a field of 0xFFFF divides by -1 and 0x8000 divides by -32768.
- R3: For a nonzero divisor outside the R5 case, the quotient truncates toward zero. The remainder has the sign of the dividend (or is zero), and dividend = quotient × divisor + remainder. `flag_ov` is 0.
- R4: A divisor field of zero gives `flag_ov`=1, quotient 0xFFFFFFFF, and (when the remainder is written) the dividend as remainder.
- R5: Dividend 0x80000000 with divisor field 0xFFFF gives `flag_ov`=1, quotient 0x80000000, and remainder 0.
- R6: At the done pulse, `flag_s` equals quotient bit 31 and `flag_z` is 1 exactly when the quotient is zero.
- R7: With `rem_en`=1, `rem_wr` pulses together with `done` and `remainder` is updated. With `rem_en`=0, `rem_wr` stays 0 and `remainder` keeps its previous value.
- R8: `done` is high for exactly one cycle. It becomes visible after the 33rd rising edge that follows the edge accepting `start`. `busy` is high from the edge after acceptance until `done` rises.
- R9: A `start` while `busy` is high is ignored. The running division completes with its original operands.
- R10: `abort` while `busy` drops `busy` on the next edge, suppresses `done`, and leaves the quotient, remainder and flag outputs unchanged. A later start produces a correct result.
- R11: After synchronous reset, `busy`, `done`, `rem_wr`, all flags, `quotient` and `remainder` are 0.
- R12: `quotient`, `remainder` and the flags change only on a cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a division when idle |
| rem_en | input | 1 | 1: also write the remainder (three-operand variant) |
| abort | input | 1 | Cancel the division in flight |
| dividend | input | 32 | Signed dividend word |
| divisor_op | input | 32 | Divisor operand; bits [15:0] are the signed divisor |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| rem_wr | output | 1 | Remainder write strobe, coincides with done |
| quotient | output | 32 | Signed quotient |
| remainder | output | 32 | Signed remainder |
| flag_ov | output | 1 | Overflow (divide by zero or 0x80000000 / -1) |
| flag_s | output | 1 | Quotient negative |
| flag_z | output | 1 | Quotient zero |

## Verification
A wrong bit in the partial-remainder or quotient shift register stays hidden until the done pulse, 34 cycles after start. It then shows as a wrong quotient or remainder, and the bench catches it by comparing against an arithmetic model. A stuck or wrong iteration counter shows up at once as a shifted or missing done pulse, which the latency check catches. Corrupted sign or case bits captured at start show on the first affected result as a wrong sign, a missing overflow flag, or a remainder that breaks the division identity. A sequencer that ignores abort or accepts a start while busy is caught by a spurious done pulse or by outputs that change off the done cycle.

// File: rtl/wdiv_pkg.sv
package wdiv_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned HALF_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } wdiv_state_e;

    // Classification of an operand pair, captured at start.
    typedef struct packed {
        logic neg_q;   // quotient must be negated
        logic neg_r;   // remainder must be negated
        logic dz;      // divisor field is zero
        logic ovf;     // most-negative word divided by -1
    } wdiv_cls_t;

    typedef struct packed {
        logic ov;
        logic s;
        logic z;
    } wdiv_flags_t;

    // Decide the flags from the final quotient's sign and zero status.
    function automatic wdiv_flags_t mk_flags(input logic ovf_case, input logic q_msb,
                                             input logic q_zero);
        wdiv_flags_t f;
        f.ov = ovf_case;
        f.s  = q_msb;
        f.z  = q_zero;
        return f;
    endfunction

endpackage

// File: rtl/wdiv_prep.sv
module wdiv_prep
    import wdiv_pkg::*;
#(
    parameter int unsigned DW = WORD_W,
    parameter int unsigned VW = HALF_W
) (
    input  logic [DW-1:0] dvd,
    input  logic [VW-1:0] dvs_field,
    output logic [DW-1:0] n_mag,
    output logic [DW-1:0] d_mag,
    output wdiv_cls_t     cls
);
    localparam int unsigned EXT_W = DW - VW;
    localparam logic [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};

    logic [DW-1:0] dvs_ext;

    assign dvs_ext = {{EXT_W{dvs_field[VW-1]}}, dvs_field};

    always_comb begin
        n_mag     = dvd[DW-1]     ? (~dvd + 1'b1)     : dvd;
        d_mag     = dvs_ext[DW-1] ? (~dvs_ext + 1'b1) : dvs_ext;
        cls.neg_q = dvd[DW-1] ^ dvs_ext[DW-1];
        cls.neg_r = dvd[DW-1];
        cls.dz    = (dvs_field == '0);
        cls.ovf   = (dvd == MOST_NEG) && (&dvs_field);
    end

endmodule

// File: rtl/wdiv_core.sv
module wdiv_core #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic [DW-1:0] n_mag,
    input  logic [DW-1:0] d_mag,
    output logic [DW-1:0] q_mag,
    output logic [DW-1:0] r_mag
);
    localparam int unsigned AW = DW + 2;

    logic signed [AW-1:0] acc;      // signed partial remainder
    logic        [DW-1:0] qsh;      // dividend bits out, quotient bits in
    logic        [DW-1:0] dreg;
    logic        [AW-1:0] d_ext;
    logic        [AW-1:0] shifted;
    logic        [AW-1:0] acc_nxt;
    logic        [AW-1:0] acc_fix;

    assign d_ext = {2'b00, dreg};

    always_comb begin
        shifted = {acc[AW-2:0], qsh[DW-1]};
        acc_nxt = acc[AW-1] ? (shifted + d_ext) : (shifted - d_ext);
        acc_fix = acc[AW-1] ? (acc + d_ext) : acc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            qsh  <= '0;
            dreg <= '0;
        end else if (load) begin
            acc  <= '0;
            qsh  <= n_mag;
            dreg <= d_mag;
        end else if (step) begin
            acc  <= acc_nxt;
            qsh  <= {qsh[DW-2:0], ~acc_nxt[AW-1]};
        end
    end

    assign q_mag = qsh;
    assign r_mag = acc_fix[DW-1:0];

endmodule

// File: rtl/wdiv_post.sv
module wdiv_post
    import wdiv_pkg::*;
#(
    parameter int unsigned DW = WORD_W
) (
    input  logic [DW-1:0] q_mag,
    input  logic [DW-1:0] r_mag,
    input  logic [DW-1:0] dvd,
    input  wdiv_cls_t     cls,
    output logic [DW-1:0] q_out,
    output logic [DW-1:0] r_out,
    output wdiv_flags_t   flg
);
    localparam logic [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};

    always_comb begin
        if (cls.dz) begin
            q_out = '1;
            r_out = dvd;
        end else if (cls.ovf) begin
            q_out = MOST_NEG;
            r_out = '0;
        end else begin
            q_out = cls.neg_q ? (~q_mag + 1'b1) : q_mag;
            r_out = cls.neg_r ? (~r_mag + 1'b1) : r_mag;
        end
        flg = mk_flags(cls.dz | cls.ovf, q_out[DW-1], q_out == '0);
    end

endmodule

// File: rtl/wdiv_unit.sv
module wdiv_unit
    import wdiv_pkg::*;
#(
    parameter int unsigned DW = WORD_W,
    parameter int unsigned VW = HALF_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          rem_en,
    input  logic          abort,
    input  logic [DW-1:0] dividend,
    input  logic [DW-1:0] divisor_op,
    output logic          busy,
    output logic          done,
    output logic          rem_wr,
    output logic [DW-1:0] quotient,
    output logic [DW-1:0] remainder,
    output logic          flag_ov,
    output logic          flag_s,
    output logic          flag_z
);
    localparam int unsigned CW = $clog2(DW);
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    wdiv_state_e   state;
    logic [CW-1:0] cnt;
    logic          mode_q;
    wdiv_cls_t     cls_in;
    wdiv_cls_t     cls_q;
    logic [DW-1:0] dvd_q;
    logic [DW-1:0] n_mag;
    logic [DW-1:0] d_mag;
    logic [DW-1:0] q_mag;
    logic [DW-1:0] r_mag;
    logic [DW-1:0] q_fin;
    logic [DW-1:0] r_fin;
    wdiv_flags_t   flg_fin;
    wdiv_flags_t   flg_q;
    logic          accept;
    logic          step;

    assign accept = (state == ST_IDLE) && start;
    assign step   = (state == ST_RUN) && !abort;
    assign busy   = (state != ST_IDLE);

    wdiv_prep #(.DW(DW), .VW(VW)) u_prep (
        .dvd       (dividend),
        .dvs_field (divisor_op[VW-1:0]),
        .n_mag     (n_mag),
        .d_mag     (d_mag),
        .cls       (cls_in)
    );

    wdiv_core #(.DW(DW)) u_core (
        .clk   (clk),
        .rst   (rst),
        .load  (accept),
        .step  (step),
        .n_mag (n_mag),
        .d_mag (d_mag),
        .q_mag (q_mag),
        .r_mag (r_mag)
    );

    wdiv_post #(.DW(DW)) u_post (
        .q_mag (q_mag),
        .r_mag (r_mag),
        .dvd   (dvd_q),
        .cls   (cls_q),
        .q_out (q_fin),
        .r_out (r_fin),
        .flg   (flg_fin)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            mode_q    <= 1'b0;
            cls_q     <= '0;
            dvd_q     <= '0;
            done      <= 1'b0;
            rem_wr    <= 1'b0;
            quotient  <= '0;
            remainder <= '0;
            flg_q     <= '0;
        end else begin
            done   <= 1'b0;
            rem_wr <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        cls_q  <= cls_in;
                        dvd_q  <= dividend;
                        mode_q <= rem_en;
                        cnt    <= '0;
                        state  <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (abort) begin
                        state <= ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                        if (cnt == LAST) begin
                            state <= ST_FIX;
                        end
                    end
                end
                ST_FIX: begin
                    state <= ST_IDLE;
                    if (!abort) begin
                        quotient <= q_fin;
                        flg_q    <= flg_fin;
                        done     <= 1'b1;
                        rem_wr   <= mode_q;
                        if (mode_q) begin
                            remainder <= r_fin;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign flag_ov = flg_q.ov;
    assign flag_s  = flg_q.s;
    assign flag_z  = flg_q.z;

endmodule

// File: rtl/wdiv_chk.sv
module wdiv_chk #(
    parameter int unsigned DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          abort,
    input logic          busy,
    input logic          done,
    input logic          rem_wr,
    input logic [DW-1:0] quotient,
    input logic [DW-1:0] remainder,
    input logic          flag_ov,
    input logic          flag_s,
    input logic          flag_z
);
    localparam int unsigned BW = $clog2(DW + 4) + 1;
    localparam logic [BW-1:0] BUSY_LEN = BW'(DW + 1);

    logic [BW-1:0] bcnt;

    always_ff @(posedge clk) begin
        if (rst || !busy) bcnt <= '0;
        else              bcnt <= bcnt + 1'b1;
    end

    // R8: single-cycle completion pulse
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: busy window length counted here instead of a long delay
    assert_busy_len_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (bcnt == BUSY_LEN));

    // R9: busy only rises after a start
    assert_busy_from_start_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    // R10: abort cancels at once
    assert_abort_cancel_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && abort) |=> (!busy && !done));

    // R7: remainder strobe only with completion
    assert_remwr_done_R7: assert property (@(posedge clk) disable iff (rst)
        rem_wr |-> done);

    // R12: results hold off the completion cycle
    assert_hold_results_R12: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(quotient) && $stable(remainder) && $stable(flag_ov)));

    // R4, R5: both overflow cases yield a negative quotient, never zero
    assert_ov_sign_R5: assert property (@(posedge clk) disable iff (rst)
        (done && flag_ov) |-> (flag_s && !flag_z));

endmodule

bind wdiv_unit wdiv_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .abort     (abort),
    .busy      (busy),
    .done      (done),
    .rem_wr    (rem_wr),
    .quotient  (quotient),
    .remainder (remainder),
    .flag_ov   (flag_ov),
    .flag_s    (flag_s),
    .flag_z    (flag_z)
);

// File: tb/wdiv_unit_bench.sv
`timescale 1ns/1ps
module wdiv_unit_bench;

    localparam int LAT = 34;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        rem_en = 1'b0;
    logic        abort = 1'b0;
    logic [31:0] dividend = '0;
    logic [31:0] divisor_op = '0;
    logic        busy, done, rem_wr, flag_ov, flag_s, flag_z;
    logic [31:0] quotient, remainder;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #10 clk = ~clk;

    wdiv_unit u_wdiv_unit (
        .clk(clk), .rst(rst), .start(start), .rem_en(rem_en), .abort(abort),
        .dividend(dividend), .divisor_op(divisor_op), .busy(busy), .done(done),
        .rem_wr(rem_wr), .quotient(quotient), .remainder(remainder),
        .flag_ov(flag_ov), .flag_s(flag_s), .flag_z(flag_z)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void ref_div(input logic [31:0] a, input logic [31:0] bop,
                                    output logic [31:0] q, output logic [31:0] r,
                                    output logic ov);
        logic signed [31:0] b;
        b = {{16{bop[15]}}, bop[15:0]};
        if (bop[15:0] == 16'h0) begin
            q = 32'hFFFF_FFFF; r = a; ov = 1'b1;
        end else if (a == 32'h8000_0000 && bop[15:0] == 16'hFFFF) begin
            q = 32'h8000_0000; r = 32'h0; ov = 1'b1;
        end else begin
            q = $signed(a) / b; r = $signed(a) % b; ov = 1'b0;
        end
    endfunction

    // Runs one division. poke_at > 0 drives a second start at that cycle;
    // abort_at > 0 raises abort at that cycle and the op is expected to vanish.
    task automatic run_op(input logic [31:0] a, input logic [31:0] bop, input bit mode,
                          input int poke_at, input int abort_at, input bit chk_lat,
                          input string req);
        logic [31:0] eq, er, prev_r, prev_q;
        logic        eov;
        int n;
        bit seen;
        ref_div(a, bop, eq, er, eov);
        prev_r = remainder;
        prev_q = quotient;
        @(negedge clk);
        dividend = a; divisor_op = bop; rem_en = mode; start = 1'b1;
        n = 0; seen = 1'b0;
        while (n < LAT + 10 && !seen) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            start = 1'b0; abort = 1'b0;
            if (done) seen = 1'b1;
            else if (poke_at > 0 && n == poke_at) begin
                dividend = 32'h7FFF_0000; divisor_op = 32'h0000_0003;
                rem_en = ~mode; start = 1'b1;
            end else if (abort_at > 0 && n == abort_at) begin
                abort = 1'b1;
                @(posedge clk);
                @(negedge clk);
                abort = 1'b0;
                chk(!busy, "R10 busy after abort", 32'(busy), 32'h0);
                n++;
            end
        end
        if (abort_at > 0) begin
            chk(!seen, "R10 no done after abort", 32'(seen), 32'h0);
            chk(quotient == prev_q, "R10 quotient kept", quotient, prev_q);
            chk(remainder == prev_r, "R10 remainder kept", remainder, prev_r);
        end else begin
            chk(seen, {req, " done seen"}, 32'(seen), 32'h1);
            if (chk_lat) chk(n == LAT, "R8 latency", 32'(n), 32'(LAT));
            chk(quotient == eq, {req, " quotient"}, quotient, eq);
            chk(flag_ov == eov, {req, " overflow"}, 32'(flag_ov), 32'(eov));
            chk(flag_s == eq[31], "R6 sign flag", 32'(flag_s), 32'(eq[31]));
            chk(flag_z == (eq == 0), "R6 zero flag", 32'(flag_z), 32'(eq == 0));
            chk(rem_wr == mode, "R7 rem_wr", 32'(rem_wr), 32'(mode));
            if (mode) chk(remainder == er, {req, " remainder"}, remainder, er);
            else      chk(remainder == prev_r, "R7 remainder held", remainder, prev_r);
            @(posedge clk);
            @(negedge clk);
            chk(!done, "R8 done one cycle", 32'(done), 32'h0);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        chk(!busy && !done && !rem_wr, "R11 control outputs", {29'h0, busy, done, rem_wr}, 32'h0);
        chk(quotient == 0 && remainder == 0, "R11 results", quotient | remainder, 32'h0);
        chk(!flag_ov && !flag_s && !flag_z, "R11 flags", {29'h0, flag_ov, flag_s, flag_z}, 32'h0);

        run_op(32'd100, 32'd7, 1'b1, 0, 0, 1'b1, "R3 pos/pos");
        run_op(-32'sd100, 32'd7, 1'b1, 0, 0, 1'b1, "R3 neg/pos");
        run_op(32'd100, 32'h0000_FFF9, 1'b1, 0, 0, 1'b0, "R3 pos/neg");
        run_op(-32'sd100, 32'h0000_FFF9, 1'b1, 0, 0, 1'b0, "R3 neg/neg");
        run_op(32'd1000, 32'hABCD_0005, 1'b1, 0, 0, 1'b0, "R1 upper bits ignored");
        run_op(32'd1234, 32'h0000_FFFF, 1'b1, 0, 0, 1'b0, "R2 0xFFFF is -1");
        run_op(32'h4000_0000, 32'h0000_8000, 1'b1, 0, 0, 1'b0, "R2 0x8000 is -32768");
        run_op(32'h1234_5678, 32'h5A5A_0000, 1'b1, 0, 0, 1'b1, "R4 divide by zero");
        run_op(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 0, 0, 1'b0, "R5 most negative by -1");
        run_op(32'h8000_0000, 32'h0000_0001, 1'b1, 0, 0, 1'b0, "R3 most negative by 1");
        run_op(32'd0, 32'd5, 1'b1, 0, 0, 1'b0, "R6 zero quotient");
        run_op(32'd4, 32'd9, 1'b1, 0, 0, 1'b0, "R6 small dividend");
        run_op(32'd77, 32'd5, 1'b0, 0, 0, 1'b0, "R7 two-operand");
        run_op(32'd5000, 32'd3, 1'b1, 5, 0, 1'b1, "R9 start while busy");
        run_op(32'd999, 32'd4, 1'b1, 0, 12, 1'b0, "R10 abort");
        run_op(32'd999, 32'd4, 1'b1, 0, 0, 1'b1, "R10 restart after abort");

        for (int i = 0; i < 250; i++) begin
            logic [31:0] a, b;
            a = $urandom;
            b = $urandom;
            if (i % 4 == 1) b[15:4] = '0;
            if (i % 8 == 3) a = a >>> 20;
            run_op(a, b, $urandom_range(0, 1) == 1, 0, 0, (i % 16) == 0, "R3 random");
        end

        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule